// File: doc/BRIEF.md
# Reset Cause and Soft Reset Request Register

This block is a single memory-mapped status word that sits in a host bridge's configuration space. It records why the most recent reset happened and lets software ask for a reset. Five flag bits occupy the top of the 32-bit word. The power-on cause flag is set only by the first bus reset after a true power-up. A small saturating counter of bus resets decides whether a reset is that first one. Software can clear the cause flags, and it can request a soft power-on or a soft external reset by writing ones to the two request flags.

A soft power-on request re-arms the counter, so the next bus reset is treated as a power-on again and reloads the word with only the power-on flag set. The block does not produce the system reset itself. It only emits a one-cycle request pulse that a reset controller elsewhere turns into the bus reset fed back to this block. An active-low power-on input clears the word and the counter asynchronously.

Top module: `rst_cause_reg`

## Requirements
- R1: The word is selected only when the address bits above bit 2 equal those of the base (default 0xF024) and address bit 2 is 1. Addresses 0xF020 to 0xF023 and every other offset read as zero, and writes to them change nothing.
- R2: The read value places the flags as follows: bit 31 is power-on cause, bit 30 is the soft power-on request, bit 29 is the soft external request, bit 28 is button power-on, and bit 27 is button external. Bits 26:0 always read zero, and write data in bits 26:0 has no effect.
- R3: Writing a one to bit 31, 28 or 27 clears that flag, and writing a zero leaves it unchanged.
- R4: Writing a one to bit 30 or 29 sets that flag. Writing a zero there never clears it.
- R5: A write with bit 30 set raises `reqPulse` in the cycle after the write and re-arms the counter, so the next bus reset loads the word with 0x80000000.
- R6: A write with bit 29 set and bit 30 clear raises `reqPulse` in the cycle after the write and does not re-arm the counter.
- R7: Each cycle with `busRst` high counts as one reset. If the counter was zero, the word becomes 0x80000000. Otherwise the word keeps its value.
- R8: The reset counter saturates, so any number of later bus resets never loads the word.
- R9: While `porN` is low, the word reads zero and `reqPulse` is low, with no clock edge needed. The counter is also cleared.
- R10: A write in the same cycle as `busRst` is ignored: it changes no flag, gives no pulse, and does not re-arm the counter.
- R11: `reqPulse` lasts exactly one cycle for each qualifying write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Asynchronous power-on clear, active low |
| busRst | input | 1 | Bus reset; each high cycle counts as one reset |
| regWr | input | 1 | Write strobe for the register port |
| regAddr | input | ADDR_W | Byte offset of the access |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr`, combinational |
| reqPulse | output | 1 | One-cycle reset request |

## Verification
A wrong flag bit shows up on the very next read of 0xF024, because the read path is combinational from the stored flags. A counter that wraps, or one that is not re-armed, stays hidden until the next bus reset. At that point the word either reloads to 0x80000000 or keeps its value, which is the opposite of what is expected. For that reason the bench clears the flags before a long run of resets, so that a wrap appears as a sudden power-on flag. A misdecoded request shows up as `reqPulse` being wrong one cycle after the write.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;
  localparam int DATA_W    = 32;
  localparam int NUM_FLAGS = 5;
  localparam int FLAG_LSB  = DATA_W - NUM_FLAGS;

  // flag indices within the stored field (field bit i maps to word bit FLAG_LSB+i)
  localparam int IDX_PWR_ON   = 4;
  localparam int IDX_SOFT_PWR = 3;
  localparam int IDX_SOFT_EXT = 2;
  localparam int IDX_BTN_PWR  = 1;
  localparam int IDX_BTN_EXT  = 0;

  localparam logic [NUM_FLAGS-1:0] CLR_ON_ONE = 5'b10011;
  localparam logic [NUM_FLAGS-1:0] SET_ON_ONE = 5'b01100;
  localparam logic [NUM_FLAGS-1:0] LOAD_VALUE = 5'b10000;

  typedef struct packed {
    logic wrHit;
    logic rdHit;
    logic loadPor;
  } strobe_t;
endpackage

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rst_cause_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'hF024,
  parameter int CNT_W = 2
) (
  input  logic                 clk,
  input  logic                 porN,
  input  logic                 busRst,
  input  logic                 regWr,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [NUM_FLAGS-1:0] wrFlags,
  output strobe_t              str,
  output logic                 reqPulse
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] rstCnt;
  logic addrHit;
  logic softPwr;
  logic softExt;

  assign addrHit = (regAddr[ADDR_W-1:3] == BASE[ADDR_W-1:3]) && regAddr[2];
  assign softPwr = wrFlags[IDX_SOFT_PWR];
  assign softExt = wrFlags[IDX_SOFT_EXT];

  always_comb begin
    str         = '0;
    str.rdHit   = addrHit;
    str.wrHit   = addrHit && regWr && !busRst;
    str.loadPor = busRst && (rstCnt == '0);
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      rstCnt <= '0;
    end else if (busRst) begin
      if (rstCnt != CNT_MAX) rstCnt <= rstCnt + 1'b1;
    end else if (str.wrHit && softPwr) begin
      rstCnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) reqPulse <= 1'b0;
    else       reqPulse <= str.wrHit && (softPwr || softExt);
  end

  // R5 / R6: a request pulse always follows a write strobe
  p_req_after_write_r5: assert property (@(posedge clk) disable iff (!porN)
    reqPulse |-> $past(regWr));

  // R8: saturated counter stays saturated under further resets
  p_cnt_saturate_r8: assert property (@(posedge clk) disable iff (!porN)
    (rstCnt == CNT_MAX && busRst) |=> rstCnt == CNT_MAX);

  // R10: a bus reset cycle never yields a request
  p_collision_r10: assert property (@(posedge clk) disable iff (!porN)
    busRst |=> !reqPulse);
endmodule

// File: rtl/rst_cause_datapath.sv
module rst_cause_datapath
  import rst_cause_pkg::*;
(
  input  logic                 clk,
  input  logic                 porN,
  input  strobe_t              str,
  input  logic [NUM_FLAGS-1:0] wrFlags,
  output logic [DATA_W-1:0]    rdData
);
  logic [NUM_FLAGS-1:0] flags;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk or negedge porN) begin
      if (!porN) begin
        flags[i] <= 1'b0;
      end else if (str.loadPor) begin
        flags[i] <= LOAD_VALUE[i];
      end else if (str.wrHit && wrFlags[i]) begin
        if (CLR_ON_ONE[i]) flags[i] <= 1'b0;
        else if (SET_ON_ONE[i]) flags[i] <= 1'b1;
      end
    end
  end

  assign rdData = str.rdHit ? {flags, {FLAG_LSB{1'b0}}} : '0;

  // R7: a first-reset load leaves only the power-on flag
  p_load_value_r7: assert property (@(posedge clk) disable iff (!porN)
    str.loadPor |=> flags == LOAD_VALUE);

  // R4: request flags only fall through a reset load
  p_set_only_r4: assert property (@(posedge clk) disable iff (!porN)
    ($fell(flags[IDX_SOFT_PWR]) || $fell(flags[IDX_SOFT_EXT])) |-> $past(str.loadPor));

  // R2: bits below the flag field are always zero
  p_low_zero_r2: assert property (@(posedge clk) disable iff (!porN)
    rdData[FLAG_LSB-1:0] == '0);
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rst_cause_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'hF024,
  parameter int CNT_W = 2
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              busRst,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              reqPulse
);
  strobe_t str;
  logic [NUM_FLAGS-1:0] wrFlags;

  assign wrFlags = regWdata[DATA_W-1:FLAG_LSB];

  rst_cause_ctrl #(.ADDR_W(ADDR_W), .BASE(BASE), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .porN(porN), .busRst(busRst), .regWr(regWr),
    .regAddr(regAddr), .wrFlags(wrFlags), .str(str), .reqPulse(reqPulse)
  );

  rst_cause_datapath dp_i (
    .clk(clk), .porN(porN), .str(str), .wrFlags(wrFlags), .rdData(regRdata)
  );
endmodule

// File: tb/rst_cause_reg_tb_top.sv
module rst_cause_reg_tb_top;
  logic clk = 0;
  logic porN = 0;
  logic busRst = 0;
  logic regWr = 0;
  logic [15:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic reqPulse;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rst_cause_reg dut_i (
    .clk(clk), .porN(porN), .busRst(busRst), .regWr(regWr),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .reqPulse(reqPulse)
  );

  typedef struct packed {
    logic [1:0]  op;   // 0 read, 1 write, 2 bus reset
    logic [15:0] addr;
    logic [31:0] data;
    logic [31:0] exp;  // read: data; write: pulse expected
  } vec_t;

  localparam int NV = 23;
  localparam vec_t TBL [NV] = '{
    '{2'd2, 16'h0000, 32'h0,         32'h0},          // R7 first reset
    '{2'd0, 16'hF024, 32'h0,         32'h8000_0000},  // R7
    '{2'd0, 16'hF020, 32'h0,         32'h0},          // R1
    '{2'd1, 16'hF020, 32'hFFFF_FFFF, 32'h0},          // R1
    '{2'd0, 16'hF024, 32'h0,         32'h8000_0000},  // R1
    '{2'd1, 16'hF024, 32'h2000_0000, 32'h1},          // R6
    '{2'd0, 16'hF024, 32'h0,         32'hA000_0000},  // R4
    '{2'd1, 16'hF024, 32'h0000_0000, 32'h0},          // R4
    '{2'd0, 16'hF024, 32'h0,         32'hA000_0000},  // R4
    '{2'd1, 16'hF024, 32'h8000_0000, 32'h0},          // R3
    '{2'd0, 16'hF024, 32'h0,         32'h2000_0000},  // R3
    '{2'd2, 16'h0000, 32'h0,         32'h0},          // R6 not re-armed
    '{2'd0, 16'hF024, 32'h0,         32'h2000_0000},  // R6
    '{2'd1, 16'hF024, 32'h4000_0000, 32'h1},          // R5
    '{2'd0, 16'hF024, 32'h0,         32'h6000_0000},  // R4
    '{2'd2, 16'h0000, 32'h0,         32'h0},          // R5 re-armed
    '{2'd0, 16'hF024, 32'h0,         32'h8000_0000},  // R5
    '{2'd1, 16'hF024, 32'h07FF_FFFF, 32'h0},          // R2
    '{2'd0, 16'hF024, 32'h0,         32'h8000_0000},  // R2
    '{2'd1, 16'hF100, 32'h6000_0000, 32'h0},          // R1
    '{2'd0, 16'hF024, 32'h0,         32'h8000_0000},  // R1
    '{2'd1, 16'hF026, 32'h1800_0000, 32'h0},          // R3
    '{2'd0, 16'hF027, 32'h0,         32'h8000_0000}   // R1
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doRead(input logic [15:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    regAddr = a;
    #1 check(tag, regRdata, exp);
  endtask

  task automatic doBus(input bit withWrite, input logic [31:0] d);
    @(negedge clk);
    busRst = 1;
    if (withWrite) begin regWr = 1; regAddr = 16'hF024; regWdata = d; end
    @(negedge clk);
    busRst = 0; regWr = 0;
  endtask

  task automatic doWrite(input logic [15:0] a, input logic [31:0] d, input bit expPulse, input string tag);
    @(negedge clk);
    regWr = 1; regAddr = a; regWdata = d;
    @(posedge clk);
    #1 check(tag, {31'b0, reqPulse}, {31'b0, expPulse});
    @(negedge clk);
    regWr = 0;
    @(posedge clk);
    #1 check("R11 pulse width", {31'b0, reqPulse}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset read", regRdata, 32'h0);
    porN = 1;
    doRead(16'hF024, 32'h0, "R9 cleared word");
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("vector %0d", i);
      case (TBL[i].op)
        2'd0: doRead(TBL[i].addr, TBL[i].exp, tag);
        2'd1: doWrite(TBL[i].addr, TBL[i].data, TBL[i].exp[0], tag);
        default: doBus(1'b0, 32'h0);
      endcase
    end
    // R8: clear the word, then many resets must never reload it
    doWrite(16'hF024, 32'h8000_0000, 1'b0, "R8 clear");
    for (int i = 0; i < 10; i++) doBus(1'b0, 32'h0);
    doRead(16'hF024, 32'h0, "R8 saturated");
    // R10: write colliding with bus reset is dropped
    @(negedge clk);
    busRst = 1; regWr = 1; regAddr = 16'hF024; regWdata = 32'h4000_0000;
    @(posedge clk);
    @(negedge clk);
    busRst = 0; regWr = 0;
    check("R10 no pulse", {31'b0, reqPulse}, 32'h0);
    doRead(16'hF024, 32'h0, "R10 no flag");
    doBus(1'b0, 32'h0);
    doRead(16'hF024, 32'h0, "R10 not re-armed");
    // R11 / R6 single pulse for an external request
    doWrite(16'hF024, 32'h2000_0000, 1'b1, "R11 pulse");
    doRead(16'hF024, 32'h2000_0000, "R4 ext flag");
    // R9: asynchronous power-on clear mid-cycle
    @(negedge clk);
    #1 porN = 0;
    #0.5 check("R9 async word", regRdata, 32'h0);
    check("R9 async pulse", {31'b0, reqPulse}, 32'h0);
    @(negedge clk);
    porN = 1;
    doBus(1'b0, 32'h0);
    doRead(16'hF024, 32'h8000_0000, "R9 counter cleared");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule